// File: doc/BRIEF.md
# Keyed Register Lock with Shadow Monitor

This block guards a bank of mapping configuration registers that sits outside it. A lock bit decides whether bus writes may reach the bank. When the lock bit is clear, a write to a protected address raises the matching bank write-enable in the same cycle. When it is set, that write still completes on the bus but no enable is raised, so the bank keeps its contents. The lock bit changes only through a short key sequence on the control register. That sequence is two fixed bytes, then one lock write, each inside a narrow cycle window.

An optional one-way input makes locking permanent until the next reset. The block also keeps its own shadow copy of every protected register, loaded only on accepted writes. It compares those copies with the values the bank reports back on every cycle. Any divergence, such as a disturbed storage cell, raises a sticky reset request for the system reset generator. The one-way input should be tied high unless software needs to reconfigure the bank more than once.

Top module: `keyed_map_guard`

## Requirements
- R1: A synchronous active-low reset clears the lock bit, the key sequence, the one-way history, all shadow copies and the reset request. Right after reset, protected writes are accepted without any key.
- R2: Address 0 is the control register. The lock bit changes only after three steps: a control write whose low byte is 0x46; a control write with low byte 0x57 on the very next clock cycle; then a control write 1 to 3 cycles after the 0x57 write. Bit 6 of that last write's data gives the new lock value.
- R3: The lock bit keeps its value indefinitely when no valid key sequence occurs; it does not relock or unlock by itself after writes.
- R4: While the lock bit is set, writes to addresses 1..NREG raise no bank write-enable, and the bank contents stay unchanged.
- R5: While the lock bit is clear, a write to address k (1..NREG) raises bank write-enable bit k-1 in the same cycle, and no other bit.
- R6: A wrong byte at either key step, or a gap between the two key bytes, returns the sequence to idle with the lock bit unchanged. Control writes that are not part of a complete sequence never change the lock bit.
- R7: Within the window after 0x57, a write to any non-control address aborts the sequence. Reaching the 4th cycle after 0x57 with no lock write also aborts it. An abort leaves the lock bit unchanged.
- R8: With the one-way input high, once the lock bit has been set since reset, a keyed write that would clear it is ignored. Setting the lock bit remains possible. With the input low, clearing works.
- R9: When any bank value reported back differs from its shadow copy, the reset request rises at the next clock edge. It stays high until reset, even if the values agree again.
- R10: Shadow copies change only on accepted writes, so normal accepted and discarded traffic never raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Write address: 0 is control, 1..NREG are protected registers |
| wr_data | input | DW | Write data |
| one_way_cfg | input | 1 | One-way lock option (high is restricted) |
| map_in | input | NREG*DW | Current bank contents, register i in bits [i*DW +: DW] |
| bank_we | output | NREG | Per-register write enable to the bank |
| lock_q | output | 1 | Current lock bit |
| mismatch_req | output | 1 | Sticky configuration-mismatch reset request |

## Verification
Each result has a fixed delay. The bank write-enable is combinational on the bus inputs, so the bench reads it a little after driving a write, before the clock edge. The lock bit changes at the edge that takes the lock write, and the bench reads it at the falling edge after that. The reset request is due one edge after a divergence appears on the bank inputs. Because the bench drives inputs only on falling edges, every expected value falls at a known falling edge: the one after the edge that produces it. The bench also steps key writes at exact cycle offsets to probe the window edges at +3 and +4.

// File: rtl/kmg_pkg.sv
// Shared constants and types for the keyed register lock.
// Assumes the key bytes sit in the low byte of control writes.
package kmg_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h46;
    localparam logic [7:0] KEY_SECOND = 8'h57;
    localparam int         LOCK_POS   = 6;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_e;
endpackage

// File: rtl/kmg_key_fsm.sv
// Key sequence recogniser and lock bit owner.
// Follows the two key bytes on control writes and opens a short window
// for one lock write. It also enforces the one-way option.
// Assumes ctl_wr and any_wr are single-cycle write qualifiers.
module kmg_key_fsm
    import kmg_pkg::*;
#(
    parameter int WIN_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       any_wr,
    input  logic [7:0] ctl_byte,
    input  logic       one_way,
    output logic       lock_q
);
    localparam int CW = $clog2(WIN_CYC + 1);

    key_state_e      state;
    logic [CW-1:0]   win_cnt;
    logic            ever_locked;
    logic            lock_wr;
    logic            new_val;
    logic            clear_blocked;

    // Decode the lock write and whether the one-way option forbids it.
    always_comb begin
        lock_wr       = (state == KS_OPEN) && ctl_wr;
        new_val       = ctl_byte[LOCK_POS];
        clear_blocked = one_way && ever_locked && !new_val;
    end

    // Sequence state: idle, first byte seen, or lock window open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= KS_IDLE;
            win_cnt <= '0;
        end else begin
            case (state)
                KS_IDLE: begin
                    if (ctl_wr && ctl_byte == KEY_FIRST)
                        state <= KS_HALF;
                end
                KS_HALF: begin
                    win_cnt <= '0;
                    if (ctl_wr && ctl_byte == KEY_SECOND)
                        state <= KS_OPEN;
                    else
                        state <= KS_IDLE;
                end
                KS_OPEN: begin
                    if (any_wr || win_cnt == CW'(WIN_CYC - 1))
                        state <= KS_IDLE;
                    else
                        win_cnt <= win_cnt + 1'b1;
                end
                default: state <= KS_IDLE;
            endcase
        end
    end

    // Lock bit and one-way history update on an accepted lock write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q      <= 1'b0;
            ever_locked <= 1'b0;
        end else if (lock_wr && !clear_blocked) begin
            lock_q <= new_val;
            if (new_val)
                ever_locked <= 1'b1;
        end
    end
endmodule

// File: rtl/kmg_write_gate.sv
// Address decode and lock gating for the protected bank.
// Address 0 is control; 1..NREG map to protected register enables.
module kmg_write_gate #(
    parameter int NREG = 4,
    parameter int AW   = 3
) (
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            lock_q,
    output logic [NREG-1:0] bank_we,
    output logic            ctl_wr,
    output logic            any_wr
);
    // Control and generic write qualifiers.
    always_comb begin
        ctl_wr = wr_en && (wr_addr == '0);
        any_wr = wr_en;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_we
        // Per-register enable, suppressed while locked.
        always_comb bank_we[i] = wr_en && !lock_q && (wr_addr == AW'(i + 1));
    end
endmodule

// File: rtl/kmg_shadow_mon.sv
// Shadow copies of the protected registers plus a continuous comparator.
// Assumes the bank loads wr_data on the same edge as bank_we, so a healthy
// bank always agrees with the shadows. Raises a sticky reset request.
module kmg_shadow_mon #(
    parameter int NREG = 4,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] bank_we,
    input  logic [DW-1:0]   wr_data,
    input  logic [NREG*DW-1:0] map_in,
    output logic            mismatch_req
);
    logic [NREG-1:0] diff;

    for (genvar i = 0; i < NREG; i++) begin : g_shadow
        logic [DW-1:0] shadow_q;
        // Load the shadow only on an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q <= '0;
            else if (bank_we[i])
                shadow_q <= wr_data;
        end
        // Compare the bank against its shadow every cycle.
        always_comb diff[i] = (map_in[i*DW +: DW] != shadow_q);
    end

    // Sticky request, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mismatch_req <= 1'b0;
        else if (|diff)
            mismatch_req <= 1'b1;
    end
endmodule

// File: rtl/keyed_map_guard.sv
// Top of the keyed register lock: gates writes to an external mapping
// bank, owns the keyed lock bit and watches the bank through shadows.
// Assumes the bank returns its contents on map_in and resets to zero.
module keyed_map_guard #(
    parameter int NREG    = 4,
    parameter int DW      = 16,
    parameter int WIN_CYC = 3,
    localparam int AW     = $clog2(NREG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               one_way_cfg,
    input  logic [NREG*DW-1:0] map_in,
    output logic [NREG-1:0]    bank_we,
    output logic               lock_q,
    output logic               mismatch_req
);
    logic ctl_wr;
    logic any_wr;

    kmg_write_gate #(.NREG(NREG), .AW(AW)) u_gate (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .lock_q  (lock_q),
        .bank_we (bank_we),
        .ctl_wr  (ctl_wr),
        .any_wr  (any_wr)
    );

    kmg_key_fsm #(.WIN_CYC(WIN_CYC)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .any_wr   (any_wr),
        .ctl_byte (wr_data[7:0]),
        .one_way  (one_way_cfg),
        .lock_q   (lock_q)
    );

    kmg_shadow_mon #(.NREG(NREG), .DW(DW)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_we      (bank_we),
        .wr_data      (wr_data),
        .map_in       (map_in),
        .mismatch_req (mismatch_req)
    );
endmodule

// File: rtl/kmg_checks.sv
// Property checker for keyed_map_guard, attached by bind.
module kmg_checks #(
    parameter int NREG = 4,
    parameter int AW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            one_way_cfg,
    input logic [NREG-1:0] bank_we,
    input logic            lock_q,
    input logic            mismatch_req
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!lock_q && !mismatch_req));

    a_r4_locked_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (bank_we == '0));

    a_r5_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    a_r3_lock_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_q) |-> $past(wr_en && wr_addr == '0));

    a_r8_one_way_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way_cfg && lock_q) |=> lock_q);

    a_r9_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_req |=> mismatch_req);
endmodule

bind keyed_map_guard kmg_checks #(.NREG(NREG), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .one_way_cfg  (one_way_cfg),
    .bank_we      (bank_we),
    .lock_q       (lock_q),
    .mismatch_req (mismatch_req)
);

// File: tb/keyed_map_guard_tb.sv
// Bench for keyed_map_guard: models the external bank, mixes seeded random
// traffic with directed key-sequence corner cases.
module keyed_map_guard_tb;
    localparam int NREG = 4;
    localparam int DW   = 16;
    localparam int AW   = $clog2(NREG + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [AW-1:0]      wr_addr = '0;
    logic [DW-1:0]      wr_data = '0;
    logic               one_way_cfg = 1'b0;
    logic [NREG*DW-1:0] map_in;
    logic [NREG-1:0]    bank_we;
    logic               lock_q;
    logic               mismatch_req;

    logic [DW-1:0] bank [NREG];
    logic [DW-1:0] glitch [NREG];
    logic [DW-1:0] exp_bank [NREG];
    logic          lock_exp = 1'b0;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    keyed_map_guard #(.NREG(NREG), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .one_way_cfg(one_way_cfg), .map_in(map_in),
        .bank_we(bank_we), .lock_q(lock_q), .mismatch_req(mismatch_req)
    );

    // Behavioural bank: loads on enable, clears on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) bank[i] <= '0;
            else if (bank_we[i]) bank[i] <= wr_data;
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++)
            map_in[i*DW +: DW] = bank[i] ^ glitch[i];
    end

    function automatic logic [NREG-1:0] we_model(logic [AW-1:0] a, logic lk);
        if (lk || a == 0 || a > NREG) return '0;
        return NREG'(1) << (a - 1);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one write for one cycle (called on a falling edge).
    task automatic put(logic [AW-1:0] a, logic [DW-1:0] d);
        logic [NREG-1:0] ew;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        ew = we_model(a, lock_exp);
        #1;
        check((a != 0 && lock_exp) ? "R4 discard" : "R5 enable", 32'(bank_we), 32'(ew));
        for (int i = 0; i < NREG; i++) if (ew[i]) exp_bank[i] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic key_write(logic [DW-1:0] lockdata);
        put(0, 16'h0046); put(0, 16'h0057); put(0, lockdata); idle(1);
    endtask

    task automatic bank_check(string tag);
        for (int i = 0; i < NREG; i++)
            check(tag, 32'(map_in[i*DW +: DW]), 32'(exp_bank[i]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < NREG; i++) begin glitch[i] = '0; exp_bank[i] = '0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        lock_exp = 1'b0;
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        for (int i = 0; i < NREG; i++) glitch[i] = '0;
        @(negedge clk);
        do_reset();
        check("R1 lock", 32'(lock_q), 0);
        check("R1 req", 32'(mismatch_req), 0);
        check("R1 bank", 32'(map_in), 0);

        // Random unlocked traffic, control writes avoid the first key byte.
        for (int n = 0; n < 40; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom_range(0, NREG));
            d = DW'($urandom);
            if (a == 0 && d[7:0] == 8'h46) d[7:0] = 8'h45;
            put(a, d);
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(1);
        bank_check("R5 contents");
        check("R6 stray ctl", 32'(lock_q), 0);
        check("R10 no req", 32'(mismatch_req), 0);

        key_write(16'h0040);
        check("R2 lock set", 32'(lock_q), 1);
        lock_exp = 1'b1;

        for (int n = 0; n < 20; n++) put(AW'($urandom_range(1, NREG)), DW'($urandom));
        idle(5);
        bank_check("R4 unchanged");
        check("R3 persists", 32'(lock_q), 1);
        check("R10 discard", 32'(mismatch_req), 0);

        put(0, 16'h0046); put(0, 16'h0058); put(0, 16'h0000); idle(1);
        check("R6 wrong byte", 32'(lock_q), 1);
        put(0, 16'h0046); idle(1); put(0, 16'h0057); put(0, 16'h0000); idle(1);
        check("R6 gap", 32'(lock_q), 1);
        put(0, 16'h0046); put(0, 16'h0057); idle(3); put(0, 16'h0000); idle(1);
        check("R7 late", 32'(lock_q), 1);
        put(0, 16'h0046); put(0, 16'h0057); put(2, 16'h1234); put(0, 16'h0000); idle(1);
        check("R7 intervening", 32'(lock_q), 1);
        put(0, 16'h0046); put(0, 16'h0057); idle(2); put(0, 16'h0000); idle(1);
        check("R2 window edge", 32'(lock_q), 0);
        lock_exp = 1'b0;

        one_way_cfg = 1'b1;
        key_write(16'h0040);
        check("R8 set allowed", 32'(lock_q), 1);
        lock_exp = 1'b1;
        key_write(16'h0000);
        check("R8 clear blocked", 32'(lock_q), 1);
        one_way_cfg = 1'b0;
        idle(1);
        key_write(16'h0000);
        check("R8 clear when off", 32'(lock_q), 0);
        lock_exp = 1'b0;

        put(3, 16'hBEEF); idle(1);
        check("R10 clean", 32'(mismatch_req), 0);
        glitch[1] = 16'h0100;
        @(negedge clk);
        check("R9 raise", 32'(mismatch_req), 1);
        glitch[1] = '0;
        idle(3);
        check("R9 sticky", 32'(mismatch_req), 1);

        do_reset();
        check("R1 req cleared", 32'(mismatch_req), 0);
        check("R1 lock cleared", 32'(lock_q), 0);
        put(4, 16'h0F0F); idle(1);
        check("R1 writable", 32'(map_in[3*DW +: DW]), 32'h0F0F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule